// File: doc/BRIEF.md
# Interrupt Mask Duration Monitor

This block measures, in cycles, how long each of a CPU's interrupt mask bits stays set. It has one tracker for the maskable-interrupt bit and one for the non-maskable-interrupt mask bit. Each tracker samples its bit only when the instruction-boundary strobe is high. A rising sample opens an interval and records the free-running cycle count as its start. A falling sample closes the interval, and the closing length updates three statistics: the shortest, the longest and the most recent completed interval.

The statistics go to a debug read port. A separate snapshot strobe for each tracker marks a debug read of an interval that is still open. When the open interval's current length is larger than the stored longest value, the read raises the longest value. Lengths are the modular difference of the cycle count and saturate at all ones when the length field is narrower than the counter.

Top module: `mask_span_monitor`

## Requirements
- R1: After reset every tracker is closed, and its last, longest, current and reported shortest outputs all read 0. The internal minimum holds the all-ones sentinel.
- R2: On a clock with `boundary_i` high, `mask_i[k]` = 1 and tracker k closed, the tracker opens and takes `cycle_i` as its start. Further high samples while open do not move the start.
- R3: On a clock with `boundary_i` high, `mask_i[k]` = 0 and tracker k open, the tracker closes and `last_o[k]` becomes the length. The length is (`cycle_i` minus start) modulo 2^CW.
- R4: A closing length replaces the stored minimum when smaller and the stored longest when larger. `longest_o` never decreases, and `last_o` never exceeds it.
- R5: While the stored minimum still holds the all-ones sentinel, `shortest_o[k]` reports `longest_o[k]`. Otherwise it reports the stored minimum.
- R6: On a clock with `snap_i[k]` high and tracker k open and not closing, `longest_o[k]` becomes the current length if that length is larger. The minimum and last values are left unchanged.
- R7: Mask changes on clocks with `boundary_i` low are ignored. No open, close or statistic changes at all.
- R8: Each tracker has its own state. Index 0 watches the maskable-interrupt bit, and index 1 watches the non-maskable-interrupt mask bit.
- R9: When CW > LW, a length of 2^LW or more is reported as all ones (2^LW - 1).
- R10: `current_o[k]` equals the saturated length (`cycle_i` minus start) while tracker k is open, and 0 while it is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_i | input | CW | Free-running cycle count |
| boundary_i | input | 1 | Instruction-boundary sampling strobe |
| mask_i | input | NM | Mask bits (0: maskable-interrupt bit, 1: non-maskable-interrupt mask bit) |
| snap_i | input | NM | Debug read of an open interval for each tracker |
| open_o | output | NM | Interval in progress for each tracker |
| current_o | output | NM x LW | Length of the open interval, 0 when closed |
| shortest_o | output | NM x LW | Reported shortest interval |
| longest_o | output | NM x LW | Longest interval |
| last_o | output | NM x LW | Most recent completed interval |

## Verification
The bench builds the block with CW = 10 and LW = 6, so interval lengths above 63 saturate and the cycle count wraps every 1024 cycles. A sweep of closing lengths from 0 to 75 therefore crosses the saturation limit and several counter wraps. Meanwhile the second tracker runs its own open, close and snapshot pattern. The small widths let every length and every minimum and maximum transition be compared against an arithmetic model on each clock.

// File: rtl/mask_span_pkg.sv
package mask_span_pkg;
  localparam int unsigned DEF_CW   = 32;
  localparam int unsigned DEF_LW   = 32;
  localparam int unsigned DEF_NM   = 2;
  localparam int unsigned TRK_MASKABLE = 0;
  localparam int unsigned TRK_NONMASKABLE = 1;
endpackage

// File: rtl/span_len.sv
module span_len #(
  parameter int unsigned CW = 32,
  parameter int unsigned LW = 32
) (
  input  logic [CW-1:0] now_i,
  input  logic [CW-1:0] start_i,
  output logic [LW-1:0] len_o
);
  logic [CW-1:0] diff;
  assign diff = now_i - start_i;

  generate
    if (CW > LW) begin : g_sat
      assign len_o = (|diff[CW-1:LW]) ? {LW{1'b1}} : diff[LW-1:0];
    end else if (CW == LW) begin : g_eq
      assign len_o = diff;
    end else begin : g_ext
      assign len_o = {{(LW-CW){1'b0}}, diff};
    end
  endgenerate
endmodule

// File: rtl/mask_span_tracker.sv
module mask_span_tracker #(
  parameter int unsigned CW = 32,
  parameter int unsigned LW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cycle_i,
  input  logic          sample_i,
  input  logic          mask_i,
  input  logic          snap_i,
  output logic          open_o,
  output logic [LW-1:0] cur_o,
  output logic [LW-1:0] short_o,
  output logic [LW-1:0] long_o,
  output logic [LW-1:0] last_o
);
  localparam logic [LW-1:0] SENTINEL = {LW{1'b1}};

  logic          open_q;
  logic [CW-1:0] start_q;
  logic [LW-1:0] min_q, max_q, last_q;
  logic [LW-1:0] len;

  span_len #(.CW(CW), .LW(LW)) u_len (
    .now_i  (cycle_i),
    .start_i(start_q),
    .len_o  (len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      start_q <= '0;
      min_q   <= SENTINEL;
      max_q   <= '0;
      last_q  <= '0;
    end else if (sample_i && mask_i && !open_q) begin
      open_q  <= 1'b1;
      start_q <= cycle_i;
    end else if (sample_i && !mask_i && open_q) begin
      open_q <= 1'b0;
      last_q <= len;
      if (len < min_q) min_q <= len;
      if (len > max_q) max_q <= len;
    end else if (snap_i && open_q && (len > max_q)) begin
      // debug read of an open interval can only raise the longest value
      max_q <= len;
    end
  end

  assign open_o  = open_q;
  assign cur_o   = open_q ? len : '0;
  assign short_o = (min_q == SENTINEL) ? max_q : min_q;
  assign long_o  = max_q;
  assign last_o  = last_q;
endmodule

// File: rtl/mask_span_monitor.sv
module mask_span_monitor
  import mask_span_pkg::*;
#(
  parameter int unsigned CW = DEF_CW,
  parameter int unsigned LW = DEF_LW,
  parameter int unsigned NM = DEF_NM
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CW-1:0]         cycle_i,
  input  logic                  boundary_i,
  input  logic [NM-1:0]         mask_i,
  input  logic [NM-1:0]         snap_i,
  output logic [NM-1:0]         open_o,
  output logic [NM-1:0][LW-1:0] current_o,
  output logic [NM-1:0][LW-1:0] shortest_o,
  output logic [NM-1:0][LW-1:0] longest_o,
  output logic [NM-1:0][LW-1:0] last_o
);
  generate
    for (genvar k = 0; k < NM; k++) begin : g_trk
      mask_span_tracker #(.CW(CW), .LW(LW)) u_trk (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cycle_i (cycle_i),
        .sample_i(boundary_i),
        .mask_i  (mask_i[k]),
        .snap_i  (snap_i[k]),
        .open_o  (open_o[k]),
        .cur_o   (current_o[k]),
        .short_o (shortest_o[k]),
        .long_o  (longest_o[k]),
        .last_o  (last_o[k])
      );
    end
  endgenerate
endmodule

// File: rtl/mask_span_monitor_chk.sv
module mask_span_monitor_chk #(
  parameter int unsigned CW = 32,
  parameter int unsigned LW = 32,
  parameter int unsigned NM = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [CW-1:0]         cycle_i,
  input logic                  boundary_i,
  input logic [NM-1:0]         mask_i,
  input logic [NM-1:0]         snap_i,
  input logic [NM-1:0]         open_o,
  input logic [NM-1:0][LW-1:0] current_o,
  input logic [NM-1:0][LW-1:0] shortest_o,
  input logic [NM-1:0][LW-1:0] longest_o,
  input logic [NM-1:0][LW-1:0] last_o
);
  generate
    for (genvar k = 0; k < NM; k++) begin : g_chk
      assert_open_on_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        boundary_i && mask_i[k] |=> open_o[k]);
      assert_close_on_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        boundary_i && !mask_i[k] |=> !open_o[k]);
      assert_last_le_long_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o[k] <= longest_o[k]);
      assert_long_monotonic_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        open_o[k] |=> longest_o[k] >= $past(longest_o[k]));
      assert_short_le_long_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shortest_o[k] <= longest_o[k]);
      assert_idle_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !boundary_i |=> $stable(open_o[k]) && $stable(last_o[k]));
      assert_cur_zero_closed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !open_o[k] |-> current_o[k] == '0);
    end
  endgenerate
endmodule

bind mask_span_monitor mask_span_monitor_chk #(.CW(CW), .LW(LW), .NM(NM)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cycle_i   (cycle_i),
  .boundary_i(boundary_i),
  .mask_i    (mask_i),
  .snap_i    (snap_i),
  .open_o    (open_o),
  .current_o (current_o),
  .shortest_o(shortest_o),
  .longest_o (longest_o),
  .last_o    (last_o)
);

// File: tb/mask_span_monitor_test.sv
module mask_span_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int LW = 6;
  localparam int NM = 2;
  localparam int LMAX = (1 << LW) - 1;
  localparam int CMOD = 1 << CW;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [CW-1:0]         cycle_i = '0;
  logic                  boundary_i = 1'b0;
  logic [NM-1:0]         mask_i = '0;
  logic [NM-1:0]         snap_i = '0;
  logic [NM-1:0]         open_o;
  logic [NM-1:0][LW-1:0] current_o, shortest_o, longest_o, last_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_open[NM], m_start[NM], m_min[NM], m_max[NM], m_last[NM];

  mask_span_monitor #(.CW(CW), .LW(LW), .NM(NM)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat_len(input int now, input int st);
    int d = (now - st + CMOD) % CMOD;
    return (d > LMAX) ? LMAX : d;
  endfunction

  task automatic compare_all(input string tag);
    for (int k = 0; k < NM; k++) begin
      int cur = m_open[k] ? sat_len(int'(cycle_i), m_start[k]) : 0;
      int sh = (m_min[k] == LMAX && !m_seen[k]) ? m_max[k] : m_min[k];
      chk({tag, " open"}, int'(open_o[k]), m_open[k]);
      chk({tag, " current R10"}, int'(current_o[k]), cur);
      chk({tag, " last R3"}, int'(last_o[k]), m_last[k]);
      chk({tag, " longest R4"}, int'(longest_o[k]), m_max[k]);
      chk({tag, " shortest R5"}, int'(shortest_o[k]), sh);
    end
  endtask

  // A closed length of exactly LMAX also equals the sentinel; the design then
  // reports longest, which equals LMAX too, so the model tracks it directly.
  bit m_seen[NM];

  task automatic step(input int cyc, input logic [NM-1:0] m, input logic b,
                      input logic [NM-1:0] s, input string tag);
    @(negedge clk_i);
    cycle_i = cyc[CW-1:0]; mask_i = m; boundary_i = b; snap_i = s;
    @(posedge clk_i);
    #1;
    for (int k = 0; k < NM; k++) begin
      int len = sat_len(cyc % CMOD, m_start[k]);
      if (b && m[k] && !m_open[k]) begin
        m_open[k] = 1; m_start[k] = cyc % CMOD;
      end else if (b && !m[k] && m_open[k]) begin
        m_open[k] = 0; m_last[k] = len;
        if (len < m_min[k]) m_min[k] = len;
        if (len > m_max[k]) m_max[k] = len;
      end else if (s[k] && m_open[k] && len > m_max[k]) begin
        m_max[k] = len;
      end
    end
    compare_all(tag);
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    for (int k = 0; k < NM; k++) begin
      m_open[k] = 0; m_start[k] = 0; m_min[k] = LMAX;
      m_max[k] = 0; m_last[k] = 0; m_seen[k] = 0;
    end
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    for (int k = 0; k < NM; k++) begin
      chk("R1 open", int'(open_o[k]), 0);
      chk("R1 last", int'(last_o[k]), 0);
      chk("R1 longest", int'(longest_o[k]), 0);
      chk("R1 shortest", int'(shortest_o[k]), 0);
      chk("R1 current", int'(current_o[k]), 0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R5/R6: snapshot on tracker 1 before any close
    step(100, 2'b10, 1'b1, 2'b00, "R2 open t1");
    step(120, 2'b10, 1'b0, 2'b10, "R6 snap");
    chk("R6 longest raised by snap", int'(longest_o[1]), 20);
    chk("R5 shortest mirrors longest", int'(shortest_o[1]), 20);
    step(121, 2'b00, 1'b1, 2'b00, "R3 close t1");
    chk("R4 min after first close", int'(shortest_o[1]), 21);
    step(200, 2'b10, 1'b1, 2'b00, "R2 reopen t1");
    step(230, 2'b10, 1'b1, 2'b00, "R2 start held");
    step(250, 2'b10, 1'b0, 2'b10, "R6 snap 50");
    chk("R6 longest 50", int'(longest_o[1]), 50);
    chk("R6 min untouched", int'(shortest_o[1]), 21);
    chk("R6 last untouched", int'(last_o[1]), 21);
    chk("R8 t0 last untouched", int'(last_o[0]), 0);
    chk("R8 t0 longest untouched", int'(longest_o[0]), 0);
    step(255, 2'b00, 1'b1, 2'b00, "R3 close t1 55");
    for (int k = 0; k < NM; k++) m_seen[k] = (m_min[k] != LMAX);

    // Sweep of lengths across saturation (R9) and counter wrap
    cyc = 300;
    for (int len = 0; len <= 75; len++) begin
      logic t1a, t1b, sn;
      t1a = (len % 3) != 0;
      t1b = (len % 4) == 0;
      sn = (len % 5) == 0;
      step(cyc, {t1a, 1'b1}, 1'b1, 2'b00, "R2 sweep open");
      step(cyc, {1'b0, 1'b0}, 1'b0, 2'b00, "R7 idle mask drop");
      step(cyc + len / 2, {t1a, 1'b1}, 1'b1, {sn, 1'b0}, "R10 sweep mid");
      step(cyc + len, {t1b, 1'b0}, 1'b1, 2'b00, "R3 R4 R9 sweep close");
      for (int k = 0; k < NM; k++) m_seen[k] = (m_min[k] != LMAX);
      if (len == 70) chk("R9 saturated last", int'(last_o[0]), LMAX);
      cyc = cyc + len + 3 + (len % 7);
    end
    chk("R4 min over sweep", int'(shortest_o[0]), 0);
    chk("R9 max saturated", int'(longest_o[0]), LMAX);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule